// File: doc/BRIEF.md
# Dual-link LVDS pixel distributor

This block sits between a pixel source that delivers one pixel per clock and the two lane serializers of an LVDS transmitter. Each incoming pixel is already split into a number of logical lanes (five lanes of seven bits by default). The block decides which link each pixel travels on. It then routes logical lanes to physical lanes for each link through a table of small selection codes.

In single-link mode every accepted pixel is forwarded to link 1, and link 2 stays silent. In dual-link mode pixels are taken in pairs. The first pixel of a pair is parked in a register. When its partner arrives, both links are loaded in the same cycle with one shared strobe, so each link runs at half the pixel rate. A phase input chooses whether link 1 carries the even or the odd pixels. The pixel count restarts at every rising edge of the data-enable input. Horizontal sync, vertical sync and data enable are copied to the links with the same one-cycle delay as the data.

Top module: `lvds_pair_splitter`

## Requirements
- R1: While `rst` is high, every output is 0 on the following clock edge, whatever the other inputs do.
- R2: With `dual_mode` low, each cycle with `pix_valid` high produces `l1_valid` high one cycle later, with `l1_data` taken from that pixel. `l1_valid` is low after a cycle without a pixel. `l2_valid`, `l2_data`, `l2_hs`, `l2_vs` and `l2_de` are all 0.
- R3: With `dual_mode` high, an even-indexed pixel produces no strobe. The odd-indexed pixel that follows it (idle cycles in between are allowed) makes `l1_valid` and `l2_valid` rise together one cycle later. Both data outputs load in that same cycle, and a strobe is never followed directly by another.
- R4: With `phase_odd` low, link 1 takes the even pixel of each pair and link 2 the odd one. With `phase_odd` high, the roles are swapped.
- R5: A pixel accepted in a cycle where `de` is high and was low in the previous cycle is even-indexed. An even pixel left without a partner when a new line starts is discarded.
- R6: Physical lane k of a link (bits [7k+6:7k]) carries the logical lane named by the 4-bit code in bits [4k+3:4k] of that link's routing word. Codes 0 to 4 pick lane c of the link-1 pixel, codes 5 to 9 pick lane c-5 of the link-2 pixel, and codes 10 to 15 give zeros. Logical lane j of a pixel is bits [7j+6:7j].
- R7: In single-link mode there is no link-2 pixel, so codes 5 to 9 give zeros on link 1. The link-2 routing word is held cleared and has no effect on any output.
- R8: `l1_hs`, `l1_vs` and `l1_de` equal `hsync`, `vsync` and `de` from the previous cycle in every mode. The link-2 copies do the same only in dual-link mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 0 single-link, 1 dual-link (both links) |
| phase_odd | input | 1 | 0: link 1 even pixels; 1: link 1 odd pixels |
| route1 | input | 20 | Link-1 lane routing codes, 4 bits per physical lane |
| route2 | input | 20 | Link-2 lane routing codes, used in dual-link mode only |
| pix_valid | input | 1 | A pixel is present this cycle |
| pix_data | input | 35 | Pixel as five 7-bit logical lanes |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable; rising edge starts a line |
| l1_valid | output | 1 | Link-1 word strobe |
| l1_data | output | 35 | Link-1 physical lanes |
| l1_hs | output | 1 | Link-1 horizontal sync |
| l1_vs | output | 1 | Link-1 vertical sync |
| l1_de | output | 1 | Link-1 data enable |
| l2_valid | output | 1 | Link-2 word strobe |
| l2_data | output | 35 | Link-2 physical lanes |
| l2_hs | output | 1 | Link-2 horizontal sync |
| l2_vs | output | 1 | Link-2 vertical sync |
| l2_de | output | 1 | Link-2 data enable |

## Verification
The properties checked on every cycle cover the timing and the mode rules. They are: the silence of link 2 in single-link mode, the one-cycle copy of the sync signals, strobe-for-pixel timing in single-link mode, equal strobes on both links, and the ban on back-to-back strobes in dual-link mode. Which pixel lands on which link needs the bench's scenarios, which track the pixel index themselves. The same goes for the phase swap, the parity restart at a line start and the discarding of an orphaned pixel. Lane routing through default, custom and out-of-range codes is also checked only by the scenarios.

// File: rtl/lvds_pair_pkg.sv
package lvds_pair_pkg;
  // Control signals that travel alongside pixel data
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } sync_t;
endpackage

// File: rtl/lvds_pair_collector.sv
// Tracks pixel parity within a line and pairs pixels for dual-link use.
module lvds_pair_collector #(
  parameter int PIX_W = 35
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dual_mode,
  input  logic             phase_odd,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             de,
  output logic             emit,
  output logic [PIX_W-1:0] pix_a,
  output logic [PIX_W-1:0] pix_b
);
  logic             de_q;
  logic             odd_next;
  logic             cur_odd;
  logic [PIX_W-1:0] held;

  // A line start forces the current pixel to index zero
  assign cur_odd = (de && !de_q) ? 1'b0 : odd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q     <= 1'b0;
      odd_next <= 1'b0;
      held     <= '0;
    end else begin
      de_q <= de;
      if (pix_valid) begin
        odd_next <= ~cur_odd;
        if (!cur_odd) held <= pix_data;
      end
    end
  end

  always_comb begin
    if (dual_mode) begin
      emit  = pix_valid && cur_odd;
      pix_a = phase_odd ? pix_data : held;
      pix_b = phase_odd ? held : pix_data;
    end else begin
      emit  = pix_valid;
      pix_a = pix_data;
      pix_b = '0;
    end
  end
endmodule

// File: rtl/lvds_lane_router.sv
// Maps logical lanes of two pixels onto physical lanes using per-lane codes.
module lvds_lane_router #(
  parameter int LANES  = 5,
  parameter int LANE_W = 7,
  parameter int CODE_W = 4
) (
  input  logic [LANES*CODE_W-1:0] codes,
  input  logic [LANES*LANE_W-1:0] pix_a,
  input  logic [LANES*LANE_W-1:0] pix_b,
  output logic [LANES*LANE_W-1:0] lanes_o
);
  localparam int SOURCES = 2 * LANES;

  initial begin
    if ((1 << CODE_W) < SOURCES)
      $display("lvds_lane_router: CODE_W too narrow for %0d sources", SOURCES);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_phys
    logic [CODE_W-1:0] code;
    assign code = codes[k*CODE_W +: CODE_W];
    always_comb begin
      lanes_o[k*LANE_W +: LANE_W] = '0;
      for (int j = 0; j < LANES; j++) begin
        if (code == CODE_W'(j))
          lanes_o[k*LANE_W +: LANE_W] = pix_a[j*LANE_W +: LANE_W];
        if (code == CODE_W'(j + LANES))
          lanes_o[k*LANE_W +: LANE_W] = pix_b[j*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/lvds_pair_splitter.sv
// Top: distributes pixels to one or two LVDS links with lane routing.
module lvds_pair_splitter #(
  parameter int LANES  = 5,
  parameter int LANE_W = 7,
  parameter int CODE_W = 4,
  localparam int PIX_W  = LANES * LANE_W,
  localparam int DIST_W = LANES * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dual_mode,
  input  logic              phase_odd,
  input  logic [DIST_W-1:0] route1,
  input  logic [DIST_W-1:0] route2,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              de,
  output logic              l1_valid,
  output logic [PIX_W-1:0]  l1_data,
  output logic              l1_hs,
  output logic              l1_vs,
  output logic              l1_de,
  output logic              l2_valid,
  output logic [PIX_W-1:0]  l2_data,
  output logic              l2_hs,
  output logic              l2_vs,
  output logic              l2_de
);
  import lvds_pair_pkg::*;

  localparam int LINKS = 2;

  logic             emit;
  logic [PIX_W-1:0] pix_a, pix_b;
  logic [DIST_W-1:0] codes [LINKS];
  logic [PIX_W-1:0]  routed [LINKS];
  sync_t             sync_in, sync1_q, sync2_q;

  assign sync_in = '{hs: hsync, vs: vsync, de: de};

  // Link-2 routing is held cleared outside dual-link mode
  assign codes[0] = route1;
  assign codes[1] = dual_mode ? route2 : '0;

  lvds_pair_collector #(.PIX_W(PIX_W)) u_collect (
    .clk       (clk),
    .rst       (rst),
    .dual_mode (dual_mode),
    .phase_odd (phase_odd),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .de        (de),
    .emit      (emit),
    .pix_a     (pix_a),
    .pix_b     (pix_b)
  );

  for (genvar l = 0; l < LINKS; l++) begin : g_link
    lvds_lane_router #(.LANES(LANES), .LANE_W(LANE_W), .CODE_W(CODE_W)) u_route (
      .codes   (codes[l]),
      .pix_a   (pix_a),
      .pix_b   (pix_b),
      .lanes_o (routed[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l1_valid <= 1'b0;
      l1_data  <= '0;
      l2_valid <= 1'b0;
      l2_data  <= '0;
      sync1_q  <= '0;
      sync2_q  <= '0;
    end else begin
      l1_valid <= emit;
      if (emit) l1_data <= routed[0];
      sync1_q  <= sync_in;
      l2_valid <= emit && dual_mode;
      if (!dual_mode) begin
        l2_data <= '0;
        sync2_q <= '0;
      end else begin
        if (emit) l2_data <= routed[1];
        sync2_q <= sync_in;
      end
    end
  end

  assign l1_hs = sync1_q.hs;
  assign l1_vs = sync1_q.vs;
  assign l1_de = sync1_q.de;
  assign l2_hs = sync2_q.hs;
  assign l2_vs = sync2_q.vs;
  assign l2_de = sync2_q.de;
endmodule

// File: rtl/lvds_pair_splitter_chk.sv
module lvds_pair_splitter_chk #(
  parameter int PIX_W = 35
) (
  input logic             clk,
  input logic             rst,
  input logic             dual_mode,
  input logic             pix_valid,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic             l1_valid,
  input logic             l1_hs,
  input logic             l1_vs,
  input logic             l1_de,
  input logic             l2_valid,
  input logic [PIX_W-1:0] l2_data,
  input logic             l2_hs,
  input logic             l2_vs,
  input logic             l2_de
);
  // R2
  l2_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode)) |->
      (!l2_valid && l2_data == '0 && !l2_hs && !l2_vs && !l2_de));

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode)) |-> (l1_valid == $past(pix_valid)));

  // R3
  joint_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dual_mode)) |-> (l1_valid == l2_valid));

  // R3
  no_burst_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dual_mode) && dual_mode && l1_valid) |=> !l1_valid);

  // R8
  sync1_copy_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (l1_hs == $past(hsync) && l1_vs == $past(vsync) && l1_de == $past(de)));

  // R8
  sync2_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dual_mode)) |->
      (l2_hs == $past(hsync) && l2_vs == $past(vsync) && l2_de == $past(de)));
endmodule

bind lvds_pair_splitter lvds_pair_splitter_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dual_mode (dual_mode),
  .pix_valid (pix_valid),
  .hsync     (hsync),
  .vsync     (vsync),
  .de        (de),
  .l1_valid  (l1_valid),
  .l1_hs     (l1_hs),
  .l1_vs     (l1_vs),
  .l1_de     (l1_de),
  .l2_valid  (l2_valid),
  .l2_data   (l2_data),
  .l2_hs     (l2_hs),
  .l2_vs     (l2_vs),
  .l2_de     (l2_de)
);

// File: tb/lvds_pair_splitter_bench.sv
module lvds_pair_splitter_bench;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        dual_mode, phase_odd;
  logic [19:0] route1, route2;
  logic        pix_valid;
  logic [34:0] pix_data;
  logic        hsync, vsync, de;
  logic        l1_valid, l1_hs, l1_vs, l1_de;
  logic        l2_valid, l2_hs, l2_vs, l2_de;
  logic [34:0] l1_data, l2_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  lvds_pair_splitter u_lvds_pair_splitter (
    .clk(clk), .rst(rst), .dual_mode(dual_mode), .phase_odd(phase_odd),
    .route1(route1), .route2(route2), .pix_valid(pix_valid), .pix_data(pix_data),
    .hsync(hsync), .vsync(vsync), .de(de),
    .l1_valid(l1_valid), .l1_data(l1_data), .l1_hs(l1_hs), .l1_vs(l1_vs), .l1_de(l1_de),
    .l2_valid(l2_valid), .l2_data(l2_data), .l2_hs(l2_hs), .l2_vs(l2_vs), .l2_de(l2_de)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected lane routing per the code rules of R6
  function automatic logic [34:0] route(input logic [19:0] d, input logic [34:0] a,
                                        input logic [34:0] b);
    logic [34:0] r = '0;
    for (int k = 0; k < 5; k++) begin
      int c = int'(d[4*k +: 4]);
      if (c < 5)       r[7*k +: 7] = a[7*c +: 7];
      else if (c < 10) r[7*k +: 7] = b[7*(c-5) +: 7];
    end
    return r;
  endfunction

  function automatic logic [34:0] mkpix(input int n);
    return 35'(64'(n) * 64'h9E37_79B9_7F4A_7C15 >> 7);
  endfunction

  task automatic push(input logic v, input logic [34:0] p, input logic e);
    pix_valid = v;
    pix_data  = p;
    de        = e;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; dual_mode = 1'b1; phase_odd = 1'b0;
    route1 = 20'h04321; route2 = 20'h59876;
    pix_valid = 1'b1; pix_data = mkpix(1); hsync = 1'b1; vsync = 1'b1; de = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 l1_valid", 64'(l1_valid), 0);
    chk("R1 l1_data", 64'(l1_data), 0);
    chk("R1 l2_valid", 64'(l2_valid), 0);
    chk("R1 l2_data", 64'(l2_data), 0);
    chk("R1 syncs", 64'({l1_hs, l1_vs, l1_de, l2_hs, l2_vs, l2_de}), 0);
    pix_valid = 1'b0; hsync = 1'b0; vsync = 1'b0; de = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_single;
    dual_mode = 1'b0; route1 = 20'h04321; route2 = 20'h59876;
    push(0, '0, 0);
    for (int i = 0; i < 4; i++) begin
      logic [34:0] p = mkpix(10 + i);
      push(1, p, 1);
      chk("R2 l1_valid", 64'(l1_valid), 1);
      chk("R6 default route", 64'(l1_data), 64'(route(route1, p, '0)));
      chk("R2/R7 link2 silent", 64'({l2_valid, l2_data}), 0);
    end
    push(0, '0, 1);
    chk("R2 no pixel no strobe", 64'(l1_valid), 0);
    // codes above 9 and link-2 codes yield zero lanes in single mode
    route1 = 20'h7C0A2;
    begin
      logic [34:0] p = mkpix(20);
      push(1, p, 1);
      chk("R6 custom route", 64'(l1_data), 64'({14'd0, p[6:0], 7'd0, p[20:14]}));
      chk("R7 link2 codes zero", 64'(l1_data[34:28]), 0);
    end
  endtask

  task automatic t_dual(input logic ph);
    logic [34:0] p0 = mkpix(30), p1 = mkpix(31), p2 = mkpix(32), p3 = mkpix(33);
    dual_mode = 1'b1; phase_odd = ph; route1 = 20'h04321; route2 = 20'h59876;
    push(0, '0, 0);
    push(1, p0, 1);
    chk("R3 even pixel no strobe", 64'({l1_valid, l2_valid}), 0);
    push(1, p1, 1);
    chk("R3 joint strobe", 64'({l1_valid, l2_valid}), 64'b11);
    chk(ph ? "R4 phase1 link1" : "R4 phase0 link1", 64'(l1_data),
        64'(route(route1, ph ? p1 : p0, ph ? p0 : p1)));
    chk(ph ? "R4 phase1 link2" : "R4 phase0 link2", 64'(l2_data),
        64'(route(route2, ph ? p1 : p0, ph ? p0 : p1)));
    push(0, '0, 1);
    chk("R3 no back-to-back", 64'({l1_valid, l2_valid}), 0);
    push(1, p2, 1);
    chk("R3 gap even", 64'(l1_valid), 0);
    push(1, p3, 1);
    chk("R3 pair after gap", 64'({l1_valid, l2_valid}), 64'b11);
    chk("R4 pair after gap link2", 64'(l2_data),
        64'(route(route2, ph ? p3 : p2, ph ? p2 : p3)));
  endtask

  task automatic t_line_restart;
    logic [34:0] q0 = mkpix(40), q1 = mkpix(41), q2 = mkpix(42);
    logic [34:0] q3 = mkpix(43), q4 = mkpix(44);
    dual_mode = 1'b1; phase_odd = 1'b0; route1 = 20'h04321; route2 = 20'h59876;
    push(0, '0, 0);
    push(1, q0, 1);
    push(1, q1, 1);
    chk("R5 first pair", 64'(l1_valid), 1);
    push(1, q2, 1);
    chk("R5 orphan no strobe", 64'(l1_valid), 0);
    push(0, '0, 0);
    push(1, q3, 1);
    chk("R5 line start even", 64'(l1_valid), 0);
    push(1, q4, 1);
    chk("R5 restart pair valid", 64'(l1_valid), 1);
    chk("R5 orphan discarded", 64'(l1_data), 64'(route(route1, q3, q4)));
  endtask

  task automatic t_sync;
    dual_mode = 1'b0;
    hsync = 1'b1; vsync = 1'b0;
    push(0, '0, 1);
    chk("R8 link1 sync copy", 64'({l1_hs, l1_vs, l1_de}), 64'b101);
    chk("R8 link2 sync cleared", 64'({l2_hs, l2_vs, l2_de}), 0);
    dual_mode = 1'b1; hsync = 1'b0; vsync = 1'b1;
    push(0, '0, 0);
    chk("R8 link1 sync dual", 64'({l1_hs, l1_vs, l1_de}), 64'b010);
    chk("R8 link2 sync dual", 64'({l2_hs, l2_vs, l2_de}), 64'b010);
    hsync = 1'b0; vsync = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_dual(1'b0);
    t_dual(1'b1);
    t_line_restart();
    t_sync();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule